// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block follows a stream of already-decoded I2C bus events and keeps track of whether the bus runs at standard/fast timing or in high-speed mode. It takes single-cycle strobes for START or repeated START, STOP, a completed byte with its value, and an acknowledge slot with its level. It drives `hs_mode`, which downstream logic uses to switch to the faster timing set.

High-speed mode begins only after three events in order. First a START. Then a first byte of the form 0000_1xxx, which is a reserved master code. Then a NACK in the acknowledge slot that follows that byte. The mode holds through any number of repeated STARTs and transfers and ends on the first STOP. Master codes are reserved and never address a target. So the block classifies the first byte after every START: it raises `master_code_seen` for a master code and raises `addr_valid` for any other first byte, which hands that byte to an address comparator.

Top module: `hs_entry_detect`

## Requirements
- R1: After reset, `hs_mode` is low, `hs_code` is 0, and no byte is treated as a first byte until a START arrives.
- R2: START, then a first byte in 0x08..0x0F, then an acknowledge strobe with `ack_nack`=1 (NACK, SDA high) sets `hs_mode` high starting in the cycle after that acknowledge strobe.
- R3: In the cycle of the first `byte_valid` after a START, `master_code_seen` is high if the byte is 0x08..0x0F and `addr_valid` is high otherwise. The two are never high together. Later bytes in the same transfer raise neither output.
- R4: Once high, `hs_mode` stays high across repeated STARTs, address bytes and data bytes until a STOP.
- R5: `stop_pulse` drives `hs_mode` low in the following cycle.
- R6: Bits [2:0] of the master code do not affect detection: every value 0x08..0x0F qualifies, and 0x00..0x07 and 0x10..0xFF do not.
- R7: If the acknowledge strobe after a master code carries `ack_nack`=0 (ACK), `hs_mode` does not change. The detector then waits for the next START.
- R8: A START or STOP between a master code and its acknowledge strobe cancels detection, so a NACK that arrives afterwards does not enter high-speed mode.
- R9: `hs_code` equals bits [2:0] of the master code that caused entry while `hs_mode` is high, and is 0 while `hs_mode` is low.
- R10: When strobes arrive in the same cycle, STOP takes precedence over START, and START takes precedence over a byte or acknowledge strobe, which is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pulse | input | 1 | START or repeated START detected |
| stop_pulse | input | 1 | STOP detected |
| byte_valid | input | 1 | A byte has been received |
| byte_data | input | BYTE_W | Value of the received byte |
| ack_valid | input | 1 | Acknowledge slot sampled |
| ack_nack | input | 1 | 1 = NACK, 0 = ACK |
| hs_mode | output | 1 | High-speed timing selected |
| hs_code | output | ID_W | Master code identifier, 0 when not in high-speed mode |
| master_code_seen | output | 1 | First byte after START is a master code |
| addr_valid | output | 1 | First byte after START is a target address |

## Verification
The bench builds the block with its default widths: an 8-bit byte with a 3-bit identifier field. With these widths every one of the 256 byte values can be swept as the first byte after a START, so both edges of the master-code window (0x07/0x08 and 0x0F/0x10) are covered. The same sweep shows that each of the eight identifiers is captured. Directed sequences cover the ACK-instead-of-NACK case, aborts in the gap before the acknowledge strobe, and simultaneous strobes.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,  // no first byte expected
    PH_FIRST = 2'd1,  // next byte is the first after START
    PH_MCACK = 2'd2   // master code taken, waiting for its ack slot
  } phase_t;
endpackage

// File: rtl/hsd_code_classify.sv
module hsd_code_classify #(
  parameter int BYTE_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [BYTE_W-1:0] byte_data,
  output logic              is_mc,
  output logic [ID_W-1:0]   code_id
);
  localparam int PFX_W = BYTE_W - ID_W;

  // Upper field must hold the value 1: 0..01 followed by ID_W free bits
  function automatic logic f_is_mc(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:ID_W] == PFX_W'(1);
  endfunction

  assign is_mc   = f_is_mc(byte_data);
  assign code_id = byte_data[ID_W-1:0];
endmodule

// File: rtl/hsd_phase_fsm.sv
module hsd_phase_fsm
  import hsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic stop_pulse,
  input  logic byte_valid,
  input  logic is_mc,
  input  logic ack_valid,
  input  logic ack_nack,
  output logic first_byte,
  output logic enter_hs
);
  phase_t phase_q, phase_d;
  logic   bus_evt;

  assign bus_evt    = start_pulse | stop_pulse;
  assign first_byte = byte_valid & (phase_q == PH_FIRST) & ~bus_evt;
  assign enter_hs   = ack_valid & ack_nack & (phase_q == PH_MCACK) & ~bus_evt;

  always_comb begin
    phase_d = phase_q;
    if (stop_pulse)       phase_d = PH_WAIT;
    else if (start_pulse) phase_d = PH_FIRST;
    else begin
      case (phase_q)
        PH_FIRST: if (byte_valid) phase_d = is_mc ? PH_MCACK : PH_WAIT;
        PH_MCACK: if (ack_valid)  phase_d = PH_WAIT;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_WAIT;
    else        phase_q <= phase_d;
  end

  // R8: any START/STOP leaves the ack-wait phase
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MCACK && bus_evt) |=> (phase_q != PH_MCACK));
  // R10: STOP always wins
  p_stop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (phase_q == PH_WAIT));
endmodule

// File: rtl/hsd_mode_reg.sv
module hsd_mode_reg #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_pulse,
  input  logic            mc_take,
  input  logic [ID_W-1:0] code_in,
  input  logic            enter_hs,
  output logic            hs_mode,
  output logic [ID_W-1:0] hs_code
);
  logic [ID_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_mode <= 1'b0;
      hs_code <= '0;
      pend_q  <= '0;
    end else begin
      if (mc_take) pend_q <= code_in;
      if (stop_pulse) begin
        hs_mode <= 1'b0;
        hs_code <= '0;
      end else if (enter_hs) begin
        hs_mode <= 1'b1;
        hs_code <= pend_q;
      end
    end
  end

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !hs_mode);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && !stop_pulse) |=> hs_mode);
  p_code_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |-> (hs_code == '0));
endmodule

// File: rtl/hs_entry_detect.sv
module hs_entry_detect #(
  parameter int BYTE_W = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              ack_valid,
  input  logic              ack_nack,
  output logic              hs_mode,
  output logic [ID_W-1:0]   hs_code,
  output logic              master_code_seen,
  output logic              addr_valid
);
  logic            is_mc;
  logic [ID_W-1:0] code_id;
  logic            first_byte;
  logic            enter_hs;

  hsd_code_classify #(.BYTE_W(BYTE_W), .ID_W(ID_W)) u_cls (
    .byte_data(byte_data), .is_mc(is_mc), .code_id(code_id));

  hsd_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .byte_valid(byte_valid), .is_mc(is_mc), .ack_valid(ack_valid),
    .ack_nack(ack_nack), .first_byte(first_byte), .enter_hs(enter_hs));

  assign master_code_seen = first_byte & is_mc;
  assign addr_valid       = first_byte & ~is_mc;

  hsd_mode_reg #(.ID_W(ID_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .stop_pulse(stop_pulse),
    .mc_take(master_code_seen), .code_in(code_id), .enter_hs(enter_hs),
    .hs_mode(hs_mode), .hs_code(hs_code));

  // R3: a first byte is either a master code or an address, never both
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_code_seen && addr_valid));
  // R2: high-speed mode only ever starts right after a NACK slot
  p_rise_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(ack_valid && ack_nack));
endmodule

// File: tb/hs_entry_detect_tb.sv
module hs_entry_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 0, sp = 0, bv = 0, av = 0, an = 0;
  logic [7:0] bd = 0;
  logic hs_mode, mcs, addr_v;
  logic [2:0] hs_code;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int m_phase = 0;   // 0 idle, 1 expect first byte, 2 expect ack of master code
  int m_hs = 0, m_code = 0, m_pend = 0;

  always #10 clk = ~clk;

  hs_entry_detect dut_i (
    .clk(clk), .rst_n(rst_n), .start_pulse(st), .stop_pulse(sp),
    .byte_valid(bv), .byte_data(bd), .ack_valid(av), .ack_nack(an),
    .hs_mode(hs_mode), .hs_code(hs_code), .master_code_seen(mcs),
    .addr_valid(addr_v));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit reserved(input int b);
    return (b >= 8) && (b <= 15);
  endfunction

  // one cycle: drive at negedge, compare before posedge, advance model
  task automatic step(input bit s_st, input bit s_sp, input bit s_bv, input int s_bd,
                      input bit s_av, input bit s_an, input string tag);
    bit first;
    @(negedge clk);
    st = s_st; sp = s_sp; bv = s_bv; bd = 8'(s_bd); av = s_av; an = s_an;
    #2;
    first = s_bv && !s_st && !s_sp && (m_phase == 1);
    chk(tag, "hs_mode", int'(hs_mode), m_hs);
    chk(tag, "hs_code", int'(hs_code), m_code);
    chk(tag, "master_code_seen", int'(mcs), int'(first && reserved(s_bd)));
    chk(tag, "addr_valid", int'(addr_v), int'(first && !reserved(s_bd)));
    @(posedge clk);
    if (s_sp) begin m_phase = 0; m_hs = 0; m_code = 0; end
    else if (s_st) m_phase = 1;
    else if (m_phase == 1 && s_bv) begin
      if (reserved(s_bd)) begin m_phase = 2; m_pend = s_bd % 8; end
      else m_phase = 0;
    end else if (m_phase == 2 && s_av) begin
      if (s_an) begin m_hs = 1; m_code = m_pend; end
      m_phase = 0;
    end
  endtask

  task automatic idle(input string tag);   step(0,0,0,0,0,0,tag); endtask
  task automatic start(input string tag);  step(1,0,0,0,0,0,tag); endtask
  task automatic stop(input string tag);   step(0,1,0,0,0,0,tag); endtask
  task automatic rxb(input int b, input string tag); step(0,0,1,b,0,0,tag); endtask
  task automatic ack(input bit nack, input string tag); step(0,0,0,0,1,nack,tag); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset hs_mode", int'(hs_mode), 0);
    chk("R1", "reset hs_code", int'(hs_code), 0);
    rst_n = 1'b1;
    // byte before any START is not a first byte
    rxb(8'h09, "R1"); ack(1, "R1"); idle("R1");

    // basic entry with 0x08
    start("R2"); rxb(8'h08, "R2"); ack(1, "R2"); idle("R2");
    chk("R2", "entered", int'(hs_mode), 1);
    chk("R9", "code 0", int'(hs_code), 0);
    // repeated START, address, data bytes including a reserved-looking one
    start("R4"); rxb(8'hA0, "R3"); ack(0, "R4"); rxb(8'h0A, "R3"); ack(0, "R4");
    rxb(8'h55, "R4"); ack(1, "R4"); start("R4"); rxb(8'h51, "R4"); idle("R4");
    chk("R4", "held", int'(hs_mode), 1);
    stop("R5"); idle("R5");
    chk("R5", "cleared", int'(hs_mode), 0);

    // entry with 0x0F, id 7
    start("R6"); rxb(8'h0F, "R6"); ack(1, "R6"); idle("R9");
    chk("R9", "code 7", int'(hs_code), 7);
    stop("R5"); idle("R5");

    // ACK instead of NACK
    start("R7"); rxb(8'h0C, "R7"); ack(0, "R7"); ack(1, "R7"); idle("R7");
    chk("R7", "no entry", int'(hs_mode), 0);

    // abort by START and by STOP
    start("R8"); rxb(8'h0B, "R8"); start("R8"); ack(1, "R8"); idle("R8");
    chk("R8", "start abort", int'(hs_mode), 0);
    start("R8"); rxb(8'h0B, "R8"); stop("R8"); ack(1, "R8"); idle("R8");
    chk("R8", "stop abort", int'(hs_mode), 0);

    // simultaneous strobes
    start("R10"); step(1,0,1,8'h0A,0,0,"R10"); rxb(8'h0D, "R10");
    step(1,0,0,0,1,1,"R10"); idle("R10");
    chk("R10", "ack under START ignored", int'(hs_mode), 0);
    start("R10"); rxb(8'h0E, "R10"); ack(1, "R10"); idle("R10");
    step(1,1,1,8'h09,0,0,"R10"); idle("R10");
    chk("R10", "STOP beats START", int'(hs_mode), 0);
    rxb(8'h09, "R10"); idle("R10");

    // sweep all byte values
    for (int b = 0; b < 256; b++) begin
      start("R6"); rxb(b, "R3"); ack(1, "R6"); idle("R6");
      chk("R6", $sformatf("entry for 0x%02h", b), int'(hs_mode), int'(reserved(b)));
      stop("R5");
    end

    idle("R1");
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule